// File: doc/BRIEF.md
# Indirect Register Port with Auto-Increment

This block is the host-facing register access unit of a bus-interface controller. The host sees only two byte locations. The first is the address location: a write to it selects an internal register index, and a read from it returns a live auxiliary status byte. The second is the value location: every read or write there reaches the currently selected register, and the index then steps forward. Multi-byte fields, such as the 24-bit transfer counter or a run of command descriptor bytes, can therefore be streamed after a single index write.

The block holds the 26-entry register file, the auxiliary status byte and the gating that restricts access while the controller is busy. Writing the command register starts a command-in-progress window of a fixed number of clocks and presents the command code and its single-byte-transfer flag to the engine. The interrupt, external busy, parity error and data-buffer-ready inputs come from a stub of that engine.

Top module: `ireg_port`

## Requirements
- R1: After a synchronous reset, every register and the index are 0, so a value read at index 0 returns 0x00 and `xfer_count` is 0.
- R2: A write to the address location (`host_sel_addr`=1) loads the index with `host_wdata[4:0]`; bits 7:5 are dropped.
- R3: Each value access (read or write, `host_sel_addr`=0) moves the index to the next register; from 25 (or any index above 25) it moves to 0.
- R4: Indices 18, 19 and 20 hold the high, middle and low bytes of the transfer count, shown on `xfer_count` as {r18, r19, r20}; streaming three bytes from index 18 loads it most significant byte first, up to 0xFFFFFF.
- R5: A read of the address location returns the status byte: bit7 `irq_in`, bit6 last-access-ignored, bit5 busy (`busy_in` or command in progress), bit4 command in progress, bits 3:2 zero, bit1 `perr_in`, bit0 `dbr_in`.
- R6: While busy, only index 24 (command) and 25 (data) are reachable; a value access to any other index is ignored on write, returns 0x00 on read, sets the ignored bit and still steps the index.
- R7: While a command is in progress, the command register at index 24 is also blocked with the same effects as R6.
- R8: Reading the status byte clears the ignored bit; the read itself returns the value before clearing.
- R9: An accepted write to index 24 stores the byte, raises `cmd_valid` for one cycle with `cmd_code` = byte[6:0] and `cmd_single` = byte[7], and holds command-in-progress for `CIP_CYCLES` clocks.
- R10: Indices 26 to 31 hold nothing: writes there change no register and reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel_addr | input | 1 | 1 selects the address/status location, 0 the value location |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte, registered on the read edge |
| irq_in | input | 1 | Interrupt pending from the engine stub |
| busy_in | input | 1 | Engine busy from the stub |
| perr_in | input | 1 | Parity error flag from the stub |
| dbr_in | input | 1 | Data buffer ready from the stub |
| xfer_count | output | 24 | Transfer count {r18, r19, r20} |
| cmd_valid | output | 1 | One-cycle pulse after an accepted command write |
| cmd_code | output | 7 | Command code, low 7 bits of the command register |
| cmd_single | output | 1 | Single-byte-transfer flag, bit 7 of the command register |

## Verification
Every host access is sampled on one rising edge, so `host_rdata`, the index, the register contents, `xfer_count` and `cmd_valid` are all valid just after that same edge; the bench drives each strobe from a falling edge and samples one time unit after the following rising edge. The command-in-progress window opens on the edge that takes the command write and stays up for `CIP_CYCLES` edges, so the bench counts its own accesses to read the status once inside the window and once after it closes. The ignored bit shows on the first status read after the blocked access and is gone on the next one.

// File: rtl/ireg_pkg.sv
package ireg_pkg;

    localparam int BYTE_W     = 8;
    localparam int IDX_W      = 5;
    localparam int REG_COUNT  = 26;
    localparam int IDX_LAST   = REG_COUNT - 1;
    localparam int IDX_STATUS = 23;
    localparam int IDX_CMD    = 24;
    localparam int IDX_DATA   = 25;
    localparam int IDX_CNT_HI = 18;
    localparam int IDX_CNT_MD = 19;
    localparam int IDX_CNT_LO = 20;
    localparam int CNT_W      = 3 * BYTE_W;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Auxiliary status byte, most significant field first.
    typedef struct packed {
        logic       irq;
        logic       ignored;
        logic       busy;
        logic       cip;
        logic [1:0] rsvd;
        logic       perr;
        logic       dbr;
    } aux_t;

    // Kind of host access seen in a cycle.
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_IDX_WR,
        ACC_STAT_RD,
        ACC_VAL_WR,
        ACC_VAL_RD
    } acc_e;

    typedef struct packed {
        acc_e  kind;
        byte_t data;
    } host_req_t;

    function automatic idx_t next_index(idx_t cur);
        if (int'(cur) >= IDX_LAST) return '0;
        return cur + idx_t'(1);
    endfunction

    function automatic logic is_cmd_idx(idx_t i);
        return int'(i) == IDX_CMD;
    endfunction

    function automatic logic is_data_idx(idx_t i);
        return int'(i) == IDX_DATA;
    endfunction

endpackage

// File: rtl/ireg_index_ctrl.sv
module ireg_index_ctrl
    import ireg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  idx_t load_val,
    input  logic step,
    output idx_t idx
);

    always_ff @(posedge clk) begin
        if (rst)       idx <= '0;
        else if (load) idx <= load_val;
        else if (step) idx <= next_index(idx);
    end

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> idx == $past(load_val));

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !load && int'(idx) == IDX_LAST) |=> idx == '0);

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !load && int'(idx) < IDX_LAST) |=> int'(idx) == int'($past(idx)) + 1);

endmodule

// File: rtl/ireg_gate.sv
module ireg_gate
    import ireg_pkg::*;
(
    input  idx_t idx,
    input  logic busy,
    input  logic cip,
    output logic allowed
);

    always_comb begin
        if (is_cmd_idx(idx))       allowed = !cip;
        else if (is_data_idx(idx)) allowed = 1'b1;
        else                       allowed = !busy;
    end

endmodule

// File: rtl/ireg_bank.sv
module ireg_bank
    import ireg_pkg::*;
#(
    parameter int NREGS = REG_COUNT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  idx_t             idx,
    input  byte_t            wdata,
    output byte_t            rd_byte,
    output logic [CNT_W-1:0] count,
    output byte_t            cmd_byte
);

    byte_t regs [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                              regs[g] <= '0;
            else if (wr_en && idx == idx_t'(g))   regs[g] <= wdata;
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NREGS; i++)
            if (idx == idx_t'(i)) rd_byte = regs[i];
    end

    assign count    = {regs[IDX_CNT_HI], regs[IDX_CNT_MD], regs[IDX_CNT_LO]};
    assign cmd_byte = regs[IDX_CMD];

    p_count_lo_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(idx) == IDX_CNT_LO) |=> count[BYTE_W-1:0] == $past(wdata));

endmodule

// File: rtl/ireg_aux.sv
module ireg_aux
    import ireg_pkg::*;
#(
    parameter int CIP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_accept,
    input  logic blocked_hit,
    input  logic stat_rd,
    input  logic irq_in,
    input  logic busy_in,
    input  logic perr_in,
    input  logic dbr_in,
    output logic cip,
    output logic busy,
    output aux_t aux
);

    localparam int CW = $clog2(CIP_CYCLES + 1);

    logic [CW-1:0] cip_cnt;
    logic          ignored;

    always_ff @(posedge clk) begin
        if (rst)                cip_cnt <= '0;
        else if (cmd_accept)    cip_cnt <= CW'(CIP_CYCLES);
        else if (cip_cnt != '0) cip_cnt <= cip_cnt - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)              ignored <= 1'b0;
        else if (blocked_hit) ignored <= 1'b1;
        else if (stat_rd)     ignored <= 1'b0;
    end

    assign cip  = cip_cnt != '0;
    assign busy = busy_in | cip;

    always_comb begin
        aux         = '0;
        aux.irq     = irq_in;
        aux.ignored = ignored;
        aux.busy    = busy;
        aux.cip     = cip;
        aux.perr    = perr_in;
        aux.dbr     = dbr_in;
    end

    p_cip_start_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_accept |=> cip);

    p_lci_set_r6: assert property (@(posedge clk) disable iff (rst)
        blocked_hit |=> aux.ignored);

    p_lci_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !blocked_hit) |=> !aux.ignored);

endmodule

// File: rtl/ireg_port.sv
module ireg_port
    import ireg_pkg::*;
#(
    parameter int CIP_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_sel_addr,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        irq_in,
    input  logic        busy_in,
    input  logic        perr_in,
    input  logic        dbr_in,
    output logic [23:0] xfer_count,
    output logic        cmd_valid,
    output logic [6:0]  cmd_code,
    output logic        cmd_single
);

    host_req_t req;
    idx_t      idx;
    logic      allowed, cip, busy;
    byte_t     rd_byte, cmd_byte;
    aux_t      aux;
    logic      val_acc, val_wr_ok, blocked_hit, cmd_accept, stat_rd;

    always_comb begin
        req.data = host_wdata;
        if (host_sel_addr && host_wr)       req.kind = ACC_IDX_WR;
        else if (host_sel_addr && host_rd)  req.kind = ACC_STAT_RD;
        else if (host_wr)                   req.kind = ACC_VAL_WR;
        else if (host_rd)                   req.kind = ACC_VAL_RD;
        else                                req.kind = ACC_NONE;
    end

    assign val_acc     = (req.kind == ACC_VAL_WR) || (req.kind == ACC_VAL_RD);
    assign val_wr_ok   = (req.kind == ACC_VAL_WR) && allowed;
    assign blocked_hit = val_acc && !allowed;
    assign cmd_accept  = val_wr_ok && is_cmd_idx(idx);
    assign stat_rd     = req.kind == ACC_STAT_RD;

    ireg_index_ctrl u_index (
        .clk      (clk),
        .rst      (rst),
        .load     (req.kind == ACC_IDX_WR),
        .load_val (req.data[IDX_W-1:0]),
        .step     (val_acc),
        .idx      (idx)
    );

    ireg_gate u_gate (
        .idx     (idx),
        .busy    (busy),
        .cip     (cip),
        .allowed (allowed)
    );

    ireg_bank #(.NREGS(REG_COUNT)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (val_wr_ok),
        .idx      (idx),
        .wdata    (req.data),
        .rd_byte  (rd_byte),
        .count    (xfer_count),
        .cmd_byte (cmd_byte)
    );

    ireg_aux #(.CIP_CYCLES(CIP_CYCLES)) u_aux (
        .clk         (clk),
        .rst         (rst),
        .cmd_accept  (cmd_accept),
        .blocked_hit (blocked_hit),
        .stat_rd     (stat_rd),
        .irq_in      (irq_in),
        .busy_in     (busy_in),
        .perr_in     (perr_in),
        .dbr_in      (dbr_in),
        .cip         (cip),
        .busy        (busy),
        .aux         (aux)
    );

    always_ff @(posedge clk) begin
        if (rst)                         host_rdata <= '0;
        else if (stat_rd)                host_rdata <= aux;
        else if (req.kind == ACC_VAL_RD) host_rdata <= allowed ? rd_byte : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_valid <= 1'b0;
        else     cmd_valid <= cmd_accept;
    end

    assign cmd_code   = cmd_byte[6:0];
    assign cmd_single = cmd_byte[7];

    p_blocked_rd_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_VAL_RD && !allowed) |=> host_rdata == '0);

    p_cip_guard_r7: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_VAL_WR && cip && is_cmd_idx(idx)) |=> $stable(cmd_byte));

    p_cmd_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cip);

    p_busy_guard_r6: assert property (@(posedge clk) disable iff (rst)
        (req.kind == ACC_VAL_WR && busy && int'(idx) == IDX_CNT_HI) |=> $stable(xfer_count));

    p_status_rd_r5: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> host_rdata[3:2] == 2'b00);

endmodule

// File: tb/ireg_port_tb.sv
module ireg_port_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_sel_addr, host_wr, host_rd;
    logic [7:0]  host_wdata, host_rdata;
    logic        irq_in, busy_in, perr_in, dbr_in;
    logic [23:0] xfer_count;
    logic        cmd_valid, cmd_single;
    logic [6:0]  cmd_code;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] rb;

    always #10 clk = ~clk;

    ireg_port #(.CIP_CYCLES(4)) dut_i (
        .clk(clk), .rst(rst),
        .host_sel_addr(host_sel_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq_in(irq_in), .busy_in(busy_in), .perr_in(perr_in), .dbr_in(dbr_in),
        .xfer_count(xfer_count), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .cmd_single(cmd_single)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic access(logic sel, logic wr, logic [7:0] d, output logic [7:0] r);
        @(negedge clk);
        host_sel_addr = sel; host_wr = wr; host_rd = !wr; host_wdata = d;
        @(posedge clk); #1;
        r = host_rdata;
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic idx_wr(logic [7:0] v);   logic [7:0] t; access(1'b1, 1'b1, v, t); endtask
    task automatic val_wr(logic [7:0] v);   logic [7:0] t; access(1'b0, 1'b1, v, t); endtask
    task automatic val_rd(output logic [7:0] r); access(1'b0, 1'b0, 8'h00, r); endtask
    task automatic stat_rd(output logic [7:0] r); access(1'b1, 1'b0, 8'h00, r); endtask

    task automatic t_reset;
        stat_rd(rb); check("R1 status after reset", rb, 8'h00);
        check("R1 count after reset", xfer_count, 24'h0);
        val_rd(rb);  check("R1 index0 after reset", rb, 8'h00);
    endtask

    task automatic t_count;
        idx_wr(8'd18); val_wr(8'h12); val_wr(8'h34); val_wr(8'h56);
        check("R4 count msb first", xfer_count, 24'h123456);
        idx_wr(8'd18);
        val_rd(rb); check("R3 stream read 18", rb, 8'h12);
        val_rd(rb); check("R3 stream read 19", rb, 8'h34);
        val_rd(rb); check("R3 stream read 20", rb, 8'h56);
        idx_wr(8'd18); val_wr(8'hFF); val_wr(8'hFF); val_wr(8'hFF);
        check("R4 count maximum", xfer_count, 24'hFFFFFF);
    endtask

    task automatic t_wrap_mask;
        idx_wr(8'd25); val_wr(8'hA5); val_wr(8'h5A);
        idx_wr(8'd0); val_rd(rb); check("R3 wrap 25 to 0", rb, 8'h5A);
        idx_wr(8'h23); // bits 7:5 dropped -> index 3
        for (int i = 0; i < 12; i++) val_wr(8'h40 + 8'(i));
        idx_wr(8'd3);
        for (int i = 0; i < 12; i++) begin
            val_rd(rb); check("R2 masked index descriptor stream", rb, 8'h40 + 8'(i));
        end
    endtask

    task automatic t_unused;
        idx_wr(8'd30); val_wr(8'h99);
        idx_wr(8'd30); val_rd(rb); check("R10 unused index reads 0", rb, 8'h00);
        idx_wr(8'd0); val_rd(rb); check("R10 index0 untouched", rb, 8'h5A);
        check("R10 count untouched", xfer_count, 24'hFFFFFF);
    endtask

    task automatic t_status_layout;
        irq_in = 1'b1; perr_in = 1'b1; dbr_in = 1'b1;
        stat_rd(rb); check("R5 status irq perr dbr", rb, 8'h83);
        busy_in = 1'b1;
        stat_rd(rb); check("R5 status with busy", rb, 8'hA3);
        irq_in = 1'b0; perr_in = 1'b0; dbr_in = 1'b0;
    endtask

    task automatic t_busy;
        busy_in = 1'b1;
        idx_wr(8'd18); val_wr(8'hEE);
        stat_rd(rb); check("R6 ignored bit set", rb, 8'h60);
        stat_rd(rb); check("R8 ignored bit cleared", rb, 8'h20);
        idx_wr(8'd19); val_rd(rb); check("R6 blocked read 0", rb, 8'h00);
        stat_rd(rb);
        idx_wr(8'd25); val_wr(8'h3C);
        idx_wr(8'd25); val_rd(rb); check("R6 data reg open while busy", rb, 8'h3C);
        stat_rd(rb); check("R6 no ignore on data reg", rb, 8'h20);
        busy_in = 1'b0;
        check("R6 blocked write left count", xfer_count, 24'hFFFFFF);
    endtask

    task automatic t_cmd;
        idx_wr(8'd24); val_wr(8'h95);
        check("R9 cmd_valid pulse", cmd_valid, 1'b1);
        check("R9 cmd_code", cmd_code, 7'h15);
        check("R9 cmd_single", cmd_single, 1'b1);
        stat_rd(rb); check("R9 cip and busy shown", rb, 8'h30);
        check("R9 cmd_valid single cycle", cmd_valid, 1'b0);
        idx_wr(8'd24); val_wr(8'h01);
        stat_rd(rb); check("R7 cmd blocked during cip", rb, 8'h70);
        repeat (5) @(negedge clk);
        stat_rd(rb); check("R9 cip ended", rb, 8'h00);
        idx_wr(8'd24); val_rd(rb); check("R7 cmd byte kept", rb, 8'h95);
    endtask

    initial begin
        rst = 1'b1; host_sel_addr = 1'b0; host_wr = 1'b0; host_rd = 1'b0;
        host_wdata = '0; irq_in = 1'b0; busy_in = 1'b0; perr_in = 1'b0; dbr_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_count();
        t_wrap_mask();
        t_unused();
        t_status_layout();
        t_busy();
        t_cmd();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule